// File: doc/BRIEF.md
# Six-Pin Digital I/O Port with Change-of-State Interrupt

This block is a small general-purpose digital port for a control coprocessor. Each of its six pins can be set, one by one, to drive a level or to sense one. A host reaches it through two word-wide registers on a simple strobed register bus. The control word sets each pin's direction and arms its change detector. The data word carries the output levels when written. When read, it returns the pin levels together with the pending change flags.

Sensed pins pass through a synchronizer before their edges are examined. When an armed input pin rises or falls, a sticky flag is set for that pin. The shared interrupt line is pulled low while any flag is set. A read of the data word both reports and clears the flags. The interrupt line is open-drain, so the block only ever drives it low. The pad tri-state is modelled as separate output value and output enable vectors.

Top module: `dio_port`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all 0), `pin_o` is 0, all change detectors are disarmed, no flag is pending, `irq_pull_low` is 0, and a read of either register returns 0.
- R2: A write to register address 1 (control) stores bits [5:0] as direction, where 1 means output, and bits [11:6] as per-pin change enable. The value reads back unchanged from address 1, and `pin_oe` equals the direction bits from the cycle after the write.
- R3: A write to register address 0 (data) stores bits [5:0] as the output latch, which appears on `pin_o` the cycle after the write for every pin, whatever its direction. Bits [11:6] of the write are ignored.
- R4: A read of address 0 returns, in bits [5:0], the latch value for output pins and the synchronized pad level for input pins, and the pending flags in bits [11:6]. With no read strobe, `bus_rdata` is 0.
- R5: A level change on `pin_i` is seen in a data read only after two clock edges, and sets its flag on the third edge.
- R6: Both a rising and a falling edge on an armed input pin set that pin's flag and no other. The flag stays set until it is cleared.
- R7: A pin whose change enable is 0, or which is configured as an output, never sets a flag, even when its level changes.
- R8: A read of address 0 clears all flags that were pending before it. A read of address 1 leaves them alone.
- R9: An edge that would set a flag on the same clock edge as a clearing data read is not lost. The flag is set after that read.
- R10: `irq_pull_low` is 1 exactly while at least one flag is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 1 | 0 = data register, 1 = control register |
| bus_wdata | input | 12 | Write data |
| bus_rdata | output | 12 | Read data, valid during the read strobe |
| pin_i | input | 6 | Pad levels as seen from the outside |
| pin_o | output | 6 | Output latch value toward the pads |
| pin_oe | output | 6 | Per-pin pad drive enable |
| irq_pull_low | output | 1 | 1 = pull the shared interrupt line low |

## Verification
The change detector is exercised with a single rising edge and a single falling edge on an armed pin. It is also exercised with two pins rising together, which shows that flags are per pin and do not spread to neighbours. Level changes on a disarmed input, and on an output pin through a pad loopback, show that the gating by enable and by direction both work. One edge is placed so that it meets a clearing read on the same clock edge, which separates set-over-clear priority from clear-over-set. The synchronizer depth is checked by sampling both the data read and the interrupt one cycle before and at the cycle in which each should change.

// File: rtl/dio_pkg.sv
package dio_pkg;
  typedef enum logic {
    REG_DATA = 1'b0,
    REG_CTRL = 1'b1
  } dio_reg_e;
endpackage

// File: rtl/dio_sync.sv
// Multi-stage level synchronizer, one chain per bit.
module dio_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] chain_d;
  logic [STAGES-1:0][W-1:0] chain_q;

  always_comb begin
    chain_d[0] = async_i;
    for (int s = 1; s < STAGES; s++) chain_d[s] = chain_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/dio_change_det.sv
// Per-pin edge detection with sticky pending flags.
module dio_change_det #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] watch_i,
  input  logic         clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q, prev_d;
  logic [W-1:0] pend_q, pend_d;
  logic [W-1:0] hit;

  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      hit[i]    = (lvl_i[i] ^ prev_q[i]) & watch_i[i];
      // a new edge wins over a simultaneous clear
      pend_d[i] = (pend_q[i] & ~clr_i) | hit[i];
    end
  end

  assign prev_d = lvl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dio_regs.sv
// Control and data registers with read multiplexer.
module dio_regs
  import dio_pkg::*;
#(
  parameter int N  = 6,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic          rd_stb,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  input  logic [N-1:0]  lvl_i,
  input  logic [N-1:0]  pend_i,
  output logic [N-1:0]  dir_o,
  output logic [N-1:0]  ie_o,
  output logic [N-1:0]  out_o,
  output logic          data_rd_o,
  output logic [DW-1:0] rdata
);
  localparam int USED = 2 * N;

  logic          ctrl_we, data_we, ctrl_rd;
  logic [N-1:0]  dir_q, dir_d, ie_q, ie_d, out_q, out_d;
  logic [N-1:0]  pin_view;
  logic [DW-1:0] rd_word;

  assign ctrl_we   = wr_stb && (addr == REG_CTRL);
  assign data_we   = wr_stb && (addr == REG_DATA);
  assign ctrl_rd   = rd_stb && (addr == REG_CTRL);
  assign data_rd_o = rd_stb && (addr == REG_DATA);

  always_comb begin
    dir_d = dir_q;
    ie_d  = ie_q;
    out_d = out_q;
    if (ctrl_we) begin
      dir_d = wdata[N-1:0];
      ie_d  = wdata[USED-1:N];
    end
    if (data_we) out_d = wdata[N-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      ie_q  <= '0;
      out_q <= '0;
    end else begin
      dir_q <= dir_d;
      ie_q  <= ie_d;
      out_q <= out_d;
    end
  end

  assign pin_view = (dir_q & out_q) | (~dir_q & lvl_i);

  always_comb begin
    rd_word = '0;
    if (data_rd_o) begin
      rd_word[N-1:0]    = pin_view;
      rd_word[USED-1:N] = pend_i;
    end else if (ctrl_rd) begin
      rd_word[N-1:0]    = dir_q;
      rd_word[USED-1:N] = ie_q;
    end
  end

  assign rdata = rd_word;
  assign dir_o = dir_q;
  assign ie_o  = ie_q;
  assign out_o = out_q;
endmodule

// File: rtl/dio_port.sv
// Top: digital I/O port with change-of-state interrupt.
module dio_port #(
  parameter int NUM_PINS    = 6,
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic                bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_pull_low
);
  logic [1:0]          rst_sync_q;
  logic                rst_n_int;
  logic [NUM_PINS-1:0] lvl_sync, ctl_dir, ctl_ie, pend_q;
  logic                data_rd;
  logic                wr_stb, rd_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  assign wr_stb = bus_sel && bus_wr;
  assign rd_stb = bus_sel && bus_rd;

  dio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_int), .async_i(pin_i), .sync_o(lvl_sync)
  );

  dio_regs #(.N(NUM_PINS), .DW(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n_int), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .addr(bus_addr), .wdata(bus_wdata), .lvl_i(lvl_sync), .pend_i(pend_q),
    .dir_o(ctl_dir), .ie_o(ctl_ie), .out_o(pin_o), .data_rd_o(data_rd),
    .rdata(bus_rdata)
  );

  dio_change_det #(.W(NUM_PINS)) u_det (
    .clk(clk), .rst_n(rst_n_int), .lvl_i(lvl_sync),
    .watch_i(ctl_ie & ~ctl_dir), .clr_i(data_rd), .pend_o(pend_q)
  );

  assign pin_oe       = ctl_dir;
  assign irq_pull_low = |pend_q;
endmodule

// File: rtl/dio_port_chk.sv
module dio_port_chk #(
  parameter int N  = 6,
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic          bus_addr,
  input logic [DW-1:0] bus_rdata,
  input logic [N-1:0]  pin_o,
  input logic [N-1:0]  pin_oe,
  input logic          irq_pull_low,
  input logic [N-1:0]  ctl_ie,
  input logic [N-1:0]  ctl_dir,
  input logic [N-1:0]  pend_q
);
  logic ctrl_wr, data_wr, data_rd;
  assign ctrl_wr = bus_sel && bus_wr && bus_addr;
  assign data_wr = bus_sel && bus_wr && !bus_addr;
  assign data_rd = bus_sel && bus_rd && !bus_addr;

  assert_oe_only_on_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(pin_oe));

  assert_out_only_on_data_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr |=> $stable(pin_o));

  assert_read_shows_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |-> (((bus_rdata[N-1:0] ^ pin_o) & pin_oe) == '0));

  assert_flags_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rd |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  assert_irq_needs_armed_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pull_low) |-> ($past(ctl_ie & ~ctl_dir) != '0));

  assert_irq_release_by_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_pull_low) |-> $past(data_rd));
endmodule

bind dio_port dio_port_chk #(.N(NUM_PINS), .DW(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .pin_o(pin_o), .pin_oe(pin_oe), .irq_pull_low(irq_pull_low),
  .ctl_ie(ctl_ie), .ctl_dir(ctl_dir), .pend_q(pend_q)
);

// File: tb/dio_port_tb_top.sv
`timescale 1ns/1ps
module dio_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [11:0] bus_wdata = '0;
  logic [11:0] bus_rdata;
  logic [5:0]  ext_pins = '0;
  logic [5:0]  pin_i, pin_o, pin_oe;
  logic        irq_pull_low;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  // pad model: driven pins loop back, others follow the outside world
  assign pin_i = (pin_oe & pin_o) | (~pin_oe & ext_pins);

  dio_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
    .irq_pull_low(irq_pull_low)
  );

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic a, input logic [11:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  // driver: pushes the expected word, monitor compares it
  task automatic bus_read(input logic a, input logic [11:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_sel = 0; bus_rd = 0;
  endtask

  always @(negedge clk) begin : monitor
    logic [11:0] e;
    string t;
    #2;
    if (bus_sel && bus_rd) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end else if (bus_rdata !== 12'h000) begin
      check("R4 idle rdata", bus_rdata, 12'h000);
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    idle(3);
    rst_n = 1;
    idle(3);
    // R1 reset state
    check("R1 pin_oe", {6'b0, pin_oe}, 12'h000);
    check("R1 pin_o", {6'b0, pin_o}, 12'h000);
    check("R1 irq", {11'b0, irq_pull_low}, 12'h000);
    bus_read(1'b1, 12'h000, "R1 ctrl read");
    bus_read(1'b0, 12'h000, "R1 data read");

    // R3 latch written while all inputs, upper bits ignored
    bus_write(1'b0, 12'hFFF);
    check("R3 pin_o", {6'b0, pin_o}, 12'h03F);
    check("R2 oe stays input", {6'b0, pin_oe}, 12'h000);

    // R2 direction: pins 0..2 outputs
    bus_write(1'b1, 12'h007);
    check("R2 pin_oe", {6'b0, pin_oe}, 12'h007);
    bus_read(1'b1, 12'h007, "R2 ctrl readback");
    bus_read(1'b0, 12'h007, "R4 data read mixed");

    // arm pins 3..5
    bus_write(1'b1, 12'hE07);
    bus_read(1'b1, 12'hE07, "R2 ctrl readback armed");

    // R5 / R6 rising edge on pin 3
    ext_pins = 6'b001000;
    idle(1);
    check("R5 irq after one edge", {11'b0, irq_pull_low}, 12'h000);
    bus_read(1'b0, 12'h007, "R5 level not yet visible");
    check("R5 irq after two edges", {11'b0, irq_pull_low}, 12'h000);
    idle(1);
    check("R10 irq after three edges", {11'b0, irq_pull_low}, 12'h001);
    bus_read(1'b1, 12'hE07, "R8 ctrl read");
    check("R8 ctrl read keeps irq", {11'b0, irq_pull_low}, 12'h001);
    bus_read(1'b0, 12'h20F, "R6 rising flag");
    check("R8 data read clears", {11'b0, irq_pull_low}, 12'h000);

    // R6 falling edge
    ext_pins = 6'b000000;
    idle(3);
    check("R6 falling irq", {11'b0, irq_pull_low}, 12'h001);
    bus_read(1'b0, 12'h207, "R6 falling flag");
    check("R10 irq released", {11'b0, irq_pull_low}, 12'h000);

    // R7 disarmed input: only pin 5 armed
    bus_write(1'b1, 12'h807);
    ext_pins = 6'b010000;
    idle(4);
    check("R7 disarmed pin", {11'b0, irq_pull_low}, 12'h000);
    bus_read(1'b0, 12'h017, "R7 disarmed no flag");

    // R7 output pin armed but toggled through its latch
    bus_write(1'b1, 12'h847);
    bus_write(1'b0, 12'h000);
    idle(4);
    check("R7 output pin", {11'b0, irq_pull_low}, 12'h000);
    bus_read(1'b0, 12'h010, "R7 output no flag");

    // R9 edge meets clearing read
    ext_pins = 6'b110000;
    idle(2);
    bus_read(1'b0, 12'h030, "R9 read at edge");
    check("R9 flag kept", {11'b0, irq_pull_low}, 12'h001);
    bus_read(1'b0, 12'h830, "R9 flag reported");
    check("R9 cleared after", {11'b0, irq_pull_low}, 12'h000);

    // R6 two pins together, all inputs armed
    bus_write(1'b1, 12'hFC0);
    check("R2 all inputs", {6'b0, pin_oe}, 12'h000);
    ext_pins = 6'b110101;
    idle(3);
    bus_read(1'b0, 12'h175, "R6 two flags");

    // R3 latch while inputs
    bus_write(1'b0, 12'hF2A);
    check("R3 latch held", {6'b0, pin_o}, 12'h02A);

    idle(2);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule